// File: doc/BRIEF.md
# Slot-Masked TDM Serial Transmitter

This block drives the serial data pin of a time-division-multiplexed audio link. The link's bit clock runs the block, and an external frame sync marks the start of each frame. A frame has `NSLOT` slots of `SLOT_W` bits each. A mask word chooses which slots carry data. A slot whose mask bit is clear consumes no word, and for that whole slot the pin is released: the output enable is low and the data bit is held at 0.

Software or a DMA engine loads words into two small transmit FIFOs. The head of each FIFO acts as its holding register. Each channel has three outputs of its own: an empty flag, an interrupt request gated by a per-channel enable, and a request line that is high while the FIFO has room.

When the two-channel enable is low, every enabled slot draws from FIFO 0. When it is high, enabled slots take words alternately from FIFO 0 and FIFO 1, and every frame starts again at FIFO 0. If a slot finds its FIFO empty, the channel's last word is sent again and a sticky underrun flag is set for that channel. Raising the transmit enable has no effect until the next frame sync.

Top module: `tdm_tx`

## Requirements
- R1: After reset, `sd_oe` and `sd_out` are 0, `empty` is 2'b11, `req` is 2'b11, `underrun` is 2'b00, and the stored last word of each channel is 0.
- R2: A frame transmits only if `tx_en` is high when its frame sync is sampled. Raising `tx_en` mid-frame gives no output and consumes no word until the next frame sync. A cycle with `tx_en` low forces `sd_oe` low from the next cycle on.
- R3: Take the clock edge that samples `fs` high as edge 0. In the cycle after edge k, where k = s*SLOT_W + b, the pin carries bit SLOT_W-1-b of slot s's word, MSB first. After the last bit of the last slot, `sd_oe` is 0 until the next frame sync.
- R4: Mask bit s (bit 0 is slot 0) clear means slot s pops no word and holds `sd_oe` = 0 and `sd_out` = 0 for all of its bits.
- R5: With `two_ch_en` = 0, every enabled slot takes the next word of FIFO 0 in write order, and FIFO 1 is never read.
- R6: With `two_ch_en` = 1, the first enabled slot of every frame takes its word from FIFO 0. Each later enabled slot alternates between FIFO 1 and FIFO 0.
- R7: An enabled slot whose source FIFO is empty transmits that channel's last transmitted word. It also sets that channel's `underrun` bit (bit 0 is channel 0), which stays set until reset.
- R8: `empty[i]` is 1 exactly when FIFO i holds no word. A write into an empty FIFO clears it one cycle after the write edge, and `irq[i]` is `empty[i]` gated by `irq_en[i]`.
- R9: `req[i]` is 1 while FIFO i holds fewer than `DEPTH` words. A write to a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs | input | 1 | Frame sync, sampled high for one cycle |
| tx_en | input | 1 | Transmit enable |
| two_ch_en | input | 1 | Alternate enabled slots between the two FIFOs |
| slot_mask | input | NSLOT | Bit s enables slot s |
| irq_en | input | 2 | Per-channel interrupt enable |
| wr_en | input | 2 | Per-channel FIFO write strobe |
| wr_data0 | input | SLOT_W | Write word for FIFO 0 |
| wr_data1 | input | SLOT_W | Write word for FIFO 1 |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data drive enable |
| empty | output | 2 | Per-channel FIFO empty flag |
| irq | output | 2 | Per-channel interrupt request |
| req | output | 2 | Per-channel FIFO-has-room request |
| underrun | output | 2 | Per-channel sticky underrun flag |

## Verification
The sampled frame sync is edge 0, and bit k of the frame appears one register stage later, in the cycle after edge k. The bench raises `fs` at a falling edge and reads `sd_out` and `sd_oe` at each following falling edge, so sample k lands exactly on frame bit k. The idle check falls one falling edge after the last bit. The FIFO flags (`empty`, `irq`, `req`) change one cycle after a write or pop edge, and the bench reads them at the falling edge that ends the write pulse. `underrun` is read after the frame, once every slot-start pop has been registered.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    typedef enum logic {
        CH0 = 1'b0,
        CH1 = 1'b1
    } chan_e;
endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_wr, do_rd;

    always_comb begin
        d     = q;
        do_wr = wr_en && (q.cnt != CW'(DEPTH));
        do_rd = rd_en && (q.cnt != '0);
        if (do_wr) begin
            d.mem[q.wp] = wr_data;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        end
        if (do_rd) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        end
        d.cnt = q.cnt + CW'(do_wr) - CW'(do_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.mem[q.rp];
    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/tdm_tx_core.sv
module tdm_tx_core
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W = 16,
    parameter int NSLOT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic              tx_en,
    input  logic              two_ch_en,
    input  logic [NSLOT-1:0]  slot_mask,
    input  logic [SLOT_W-1:0] head0,
    input  logic [SLOT_W-1:0] head1,
    input  logic              empty0,
    input  logic              empty1,
    output logic              pop0,
    output logic              pop1,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [1:0]        underrun
);
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int BW = $clog2(SLOT_W);

    typedef struct packed {
        logic              active;
        logic              running;
        logic [SW-1:0]     slot;
        logic [BW-1:0]     bitc;
        logic [SLOT_W-1:0] shreg;
        logic              oe;
        logic              ptr;
        logic [SLOT_W-1:0] last0;
        logic [SLOT_W-1:0] last1;
        logic [1:0]        urun;
    } core_st_t;

    core_st_t q, d;
    logic              start;
    logic [SW-1:0]     s_idx;
    logic              act;
    logic              ptr_cur;
    chan_e             ch;
    logic [SLOT_W-1:0] word;

    always_comb begin
        d       = q;
        pop0    = 1'b0;
        pop1    = 1'b0;
        start   = 1'b0;
        s_idx   = '0;
        word    = '0;
        ch      = CH0;
        act     = fs ? tx_en : (q.active && tx_en);
        ptr_cur = fs ? 1'b0 : q.ptr;
        d.active = act;

        if (fs) begin
            start     = 1'b1;
            d.running = 1'b1;
        end else if (q.running) begin
            if (q.bitc == BW'(SLOT_W - 1)) begin
                if (q.slot == SW'(NSLOT - 1)) begin
                    d.running = 1'b0;
                    d.oe      = 1'b0;
                end else begin
                    start = 1'b1;
                    s_idx = q.slot + SW'(1);
                end
            end else begin
                d.bitc  = q.bitc + BW'(1);
                d.shreg = {q.shreg[SLOT_W-2:0], 1'b0};
            end
        end

        if (start) begin
            d.slot = s_idx;
            d.bitc = '0;
            d.ptr  = ptr_cur;
            if (act && slot_mask[s_idx]) begin
                ch = (two_ch_en && ptr_cur) ? CH1 : CH0;
                if (ch == CH0) begin
                    if (!empty0) begin
                        pop0    = 1'b1;
                        word    = head0;
                        d.last0 = head0;
                    end else begin
                        word      = q.last0;
                        d.urun[0] = 1'b1;
                    end
                end else begin
                    if (!empty1) begin
                        pop1    = 1'b1;
                        word    = head1;
                        d.last1 = head1;
                    end else begin
                        word      = q.last1;
                        d.urun[1] = 1'b1;
                    end
                end
                d.shreg = word;
                d.oe    = 1'b1;
                d.ptr   = two_ch_en ? ~ptr_cur : 1'b0;
            end else begin
                d.shreg = '0;
                d.oe    = 1'b0;
            end
        end

        if (!tx_en) d.oe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sd_out   = q.shreg[SLOT_W-1] & q.oe;
    assign sd_oe    = q.oe;
    assign underrun = q.urun;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
    parameter int SLOT_W = 16,
    parameter int NSLOT  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic              tx_en,
    input  logic              two_ch_en,
    input  logic [NSLOT-1:0]  slot_mask,
    input  logic [1:0]        irq_en,
    input  logic [1:0]        wr_en,
    input  logic [SLOT_W-1:0] wr_data0,
    input  logic [SLOT_W-1:0] wr_data1,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [1:0]        empty,
    output logic [1:0]        irq,
    output logic [1:0]        req,
    output logic [1:0]        underrun
);
    localparam int NCH = 2;

    logic [SLOT_W-1:0] wdata [NCH];
    logic [SLOT_W-1:0] head  [NCH];
    logic [NCH-1:0]    empty_w;
    logic [NCH-1:0]    full_w;
    logic [NCH-1:0]    pop;

    assign wdata[0] = wr_data0;
    assign wdata[1] = wr_data1;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tdm_tx_fifo #(.W(SLOT_W), .DEPTH(DEPTH)) fifo_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[i]),
            .wr_data (wdata[i]),
            .rd_en   (pop[i]),
            .rd_data (head[i]),
            .empty   (empty_w[i]),
            .full    (full_w[i])
        );
    end

    tdm_tx_core #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs        (fs),
        .tx_en     (tx_en),
        .two_ch_en (two_ch_en),
        .slot_mask (slot_mask),
        .head0     (head[0]),
        .head1     (head[1]),
        .empty0    (empty_w[0]),
        .empty1    (empty_w[1]),
        .pop0      (pop[0]),
        .pop1      (pop[1]),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe),
        .underrun  (underrun)
    );

    assign empty = empty_w;
    assign irq   = empty_w & irq_en;
    assign req   = ~full_w;
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       sd_out,
    input logic       sd_oe,
    input logic [1:0] wr_en,
    input logic [1:0] empty,
    input logic [1:0] req,
    input logic [1:0] underrun
);
    // R2: a disabled cycle releases the pin on the next cycle
    a_r2_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sd_oe);

    // R4: the data bit stays low whenever the pin is released
    a_r4_inactive_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

    // R8: a write into an empty FIFO clears its empty flag
    a_r8_write_clears_empty0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && empty[0]) |=> !empty[0]);
    a_r8_write_clears_empty1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[1] && empty[1]) |=> !empty[1]);

    // R7: underrun flags are sticky
    a_r7_underrun_sticky0: assert property (@(posedge clk) disable iff (!rst_n)
        underrun[0] |=> underrun[0]);
    a_r7_underrun_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
        underrun[1] |=> underrun[1]);

    // R9: a FIFO with no room cannot be empty
    a_r9_full_not_empty0: assert property (@(posedge clk) disable iff (!rst_n)
        !req[0] |-> !empty[0]);
    a_r9_full_not_empty1: assert property (@(posedge clk) disable iff (!rst_n)
        !req[1] |-> !empty[1]);
endmodule

bind tdm_tx tdm_tx_chk chk_i (.*);

// File: tb/tdm_tx_tb_top.sv
module tdm_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int NS = 4;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fs = 1'b0;
    logic          tx_en = 1'b0;
    logic          two_ch_en = 1'b0;
    logic [NS-1:0] slot_mask = '0;
    logic [1:0]    irq_en = '0;
    logic [1:0]    wr_en = '0;
    logic [W-1:0]  wr_data0 = '0;
    logic [W-1:0]  wr_data1 = '0;
    logic          sd_out, sd_oe;
    logic [1:0]    empty, irq, req, underrun;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [W-1:0] mq0[$];
    logic [W-1:0] mq1[$];
    logic [W-1:0] mlast [2];
    logic [1:0]   mur;

    tdm_tx #(.SLOT_W(W), .NSLOT(NS), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fs(fs), .tx_en(tx_en), .two_ch_en(two_ch_en),
        .slot_mask(slot_mask), .irq_en(irq_en), .wr_en(wr_en),
        .wr_data0(wr_data0), .wr_data1(wr_data1), .sd_out(sd_out), .sd_oe(sd_oe),
        .empty(empty), .irq(irq), .req(req), .underrun(underrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int ch, input logic [W-1:0] v);
        @(negedge clk);
        if (ch == 0) begin
            wr_data0 = v; wr_en = 2'b01;
            if (mq0.size() < DP) mq0.push_back(v);
        end else begin
            wr_data1 = v; wr_en = 2'b10;
            if (mq1.size() < DP) mq1.push_back(v);
        end
        @(negedge clk);
        wr_en = 2'b00;
    endtask

    task automatic run_frame(input string tag);
        logic [W-1:0] expw [NS];
        logic [W-1:0] gw [NS];
        logic [W-1:0] go [NS];
        logic ptr;
        int   c;
        ptr = 1'b0;
        for (int s = 0; s < NS; s++) begin
            expw[s] = '0;
            if (slot_mask[s]) begin
                c = (two_ch_en && ptr) ? 1 : 0;
                if (c == 0) begin
                    if (mq0.size() > 0) begin expw[s] = mq0.pop_front(); mlast[0] = expw[s]; end
                    else begin expw[s] = mlast[0]; mur[0] = 1'b1; end
                end else begin
                    if (mq1.size() > 0) begin expw[s] = mq1.pop_front(); mlast[1] = expw[s]; end
                    else begin expw[s] = mlast[1]; mur[1] = 1'b1; end
                end
                ptr = two_ch_en ? ~ptr : 1'b0;
            end
        end
        @(negedge clk);
        fs = 1'b1;
        for (int s = 0; s < NS; s++) begin
            for (int b = 0; b < W; b++) begin
                @(negedge clk);
                fs = 1'b0;
                gw[s][W-1-b] = sd_out;
                go[s][W-1-b] = sd_oe;
            end
        end
        for (int s = 0; s < NS; s++) begin
            if (slot_mask[s]) begin
                chk($sformatf("%s slot%0d R3 word", tag, s), 32'(gw[s]), 32'(expw[s]));
                chk($sformatf("%s slot%0d R3 oe", tag, s), 32'(go[s]), 32'({W{1'b1}}));
            end else begin
                chk($sformatf("%s slot%0d R4 data", tag, s), 32'(gw[s]), 0);
                chk($sformatf("%s slot%0d R4 oe", tag, s), 32'(go[s]), 0);
            end
        end
        @(negedge clk);
        chk({tag, " R3 idle after frame"}, 32'(sd_oe), 0);
        chk({tag, " R7 underrun"}, 32'(underrun), 32'(mur));
    endtask

    task automatic t_reset();
        chk("R1 sd_oe", 32'(sd_oe), 0);
        chk("R1 sd_out", 32'(sd_out), 0);
        chk("R1 empty", 32'(empty), 32'h3);
        chk("R1 req", 32'(req), 32'h3);
        chk("R1 underrun", 32'(underrun), 0);
        irq_en = 2'b11;
        @(negedge clk);
        chk("R8 irq when empty", 32'(irq), 32'h3);
    endtask

    task automatic t_flags();
        push(0, 8'hA5);
        chk("R8 empty0 cleared", 32'(empty), 32'h2);
        chk("R8 irq0 dropped", 32'(irq), 32'h2);
        chk("R9 req room", 32'(req), 32'h3);
        push(0, 8'h3C);
        push(0, 8'h81);
        push(0, 8'h7E);
        chk("R9 req0 full", 32'(req), 32'h2);
        push(0, 8'hFF);
        chk("R9 still full after drop", 32'(req), 32'h2);
    endtask

    task automatic t_enable_midframe();
        logic any_oe;
        any_oe = 1'b0;
        tx_en = 1'b0;
        slot_mask = 4'b1111;
        @(negedge clk);
        fs = 1'b1;
        @(negedge clk);
        fs = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < NS * W; k++) begin
            @(negedge clk);
            any_oe |= sd_oe;
        end
        chk("R2 no output after mid-frame enable", 32'(any_oe), 0);
        chk("R2 no word consumed", 32'(req), 32'h2);
    endtask

    task automatic t_single();
        push(1, 8'h5A);
        two_ch_en = 1'b0;
        slot_mask = 4'b1111;
        run_frame("single");
        chk("R5 fifo1 untouched", 32'(empty), 32'h1);
        chk("R8 fifo0 drained", 32'(irq), 32'h1);
    endtask

    task automatic t_mask();
        push(0, 8'hC3);
        push(0, 8'h96);
        slot_mask = 4'b0101;
        run_frame("mask");
        chk("R4 only two words used", 32'(empty), 32'h1);
    endtask

    task automatic t_two_ch();
        push(0, 8'h11);
        push(0, 8'h22);
        push(1, 8'h44);
        two_ch_en = 1'b1;
        slot_mask = 4'b1111;
        run_frame("two_ch R6");
        chk("R6 both drained", 32'(empty), 32'h3);
    endtask

    task automatic t_frame_ptr();
        for (int k = 0; k < 4; k++) push(0, 8'h60 + 8'(k));
        push(1, 8'hB0);
        push(1, 8'hB1);
        two_ch_en = 1'b1;
        slot_mask = 4'b0111;
        run_frame("ptr_f1 R6");
        run_frame("ptr_f2 R6");
        chk("R6 restart at fifo0", 32'(empty), 32'h3);
    endtask

    task automatic t_underrun();
        two_ch_en = 1'b0;
        slot_mask = 4'b0001;
        run_frame("under0 R7");
        two_ch_en = 1'b1;
        slot_mask = 4'b0011;
        run_frame("under1 R7");
    endtask

    task automatic t_disabled();
        logic any_oe;
        any_oe = 1'b0;
        push(0, 8'hE7);
        tx_en = 1'b0;
        slot_mask = 4'b1111;
        @(negedge clk);
        fs = 1'b1;
        for (int k = 0; k < NS * W; k++) begin
            @(negedge clk);
            fs = 1'b0;
            any_oe |= sd_oe;
        end
        chk("R2 disabled frame silent", 32'(any_oe), 0);
        chk("R2 disabled frame keeps word", 32'(empty), 32'h2);
    endtask

    initial begin
        mlast[0] = '0;
        mlast[1] = '0;
        mur = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_enable_midframe();
        t_single();
        t_mask();
        t_two_ch();
        t_frame_ptr();
        t_underrun();
        t_disabled();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule